// File: doc/BRIEF.md
# Paired-Register I2C Read/Write Slave

This block is the serial front end of a 16-bit general-purpose I/O expander. It watches an open-drain two-wire bus (clock and data), sampled by a fast system clock, and answers to a seven-bit address. The upper four bits of that address are a parameter and the lower three come from strap inputs. A write sets an internal register pointer from a command byte. Any further bytes in the same write are stored into the register file, two bytes to a pair. A read, normally issued after a repeated START, returns the pointed register first. After that it alternates between the two halves of the pair for as long as the master keeps acknowledging.

Eight register codes exist, grouped as four pairs: two input ports, two output latches, two polarity-inversion masks and two configuration bytes. Input bytes are returned through their polarity mask. The byte to be sent is captured on the rising clock edge of the acknowledge bit that comes before it. If a repeated START arrives while a read is in progress, the stored pointer takes the value of the register that was being read. A following read therefore resumes there.

Controller states and transitions: `ST_IDLE` goes to `ST_ADDR` on START. `ST_ADDR` goes to `ST_ADDR_ACK` on an address match, or back to `ST_IDLE` on a mismatch. `ST_ADDR_ACK` goes to `ST_RD` for a read or to `ST_CMD` for a write. `ST_CMD` goes to `ST_CMD_ACK`, which goes to `ST_WR`. `ST_WR` goes to `ST_WR_ACK`, which goes back to `ST_WR`. `ST_RD` goes to `ST_RD_ACK`, which goes to `ST_RD` on a master ACK or to `ST_IDLE` on a NACK. From any state, STOP leads to `ST_IDLE` and START leads to `ST_ADDR`.

Top module: `i2c_pair_slave`

## Requirements
- R1: An address byte whose upper seven bits equal ADDR_HI followed by the three strap bits is acknowledged (SDA pulled low in the ninth clock). Any other address is not acknowledged, and the slave then leaves SDA alone until the next START.
- R2: The low three bits of the command byte set the pointer, and its upper five bits are ignored. Codes 0/1 are input ports, 2/3 output latches, 4/5 polarity masks and 6/7 configuration bytes.
- R3: Data bytes that follow the command in a write go to the pointed register, and each further byte goes to the register whose code differs in bit 0.
- R4: A read returns the pointed register first. Each byte the master acknowledges is followed by the partner register (code XOR 1), without limit.
- R5: A read of code 0 or 1 returns the input port XORed with polarity mask 4 or 5 respectively.
- R6: A repeated START during a read replaces the stored pointer with the code of the register last read. The old pointer is lost, and the next read begins at the new one.
- R7: The byte sent is captured at the rising SCL edge of the acknowledge bit before it. Input changes after that edge do not affect that byte.
- R8: After a master NACK the slave releases SDA. The slave never drives SDA while the master is driving a bit, START or STOP.
- R9: A STOP at any point returns the slave to idle without latching a partial byte. The next transfer works normally.
- R10: Writes to codes 0 and 1 are ignored.
- R11: After reset the output latches and configuration bytes read 0xFF, the polarity masks read 0x00, the pointer is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| strap_i | input | 3 | Low three address bits |
| port0_i | input | 8 | Input port, code 0 |
| port1_i | input | 8 | Input port, code 1 |

## Verification
The bench builds the block with its default ADDR_HI of 0100 and two synchroniser stages, and ties the straps to 101. This places the device at bus address 0x25, so address 0x27 serves as a mismatch that differs only in a strap bit. Each bus bit is held for forty system clocks. This leaves the synchroniser delay well inside every phase, so per-clock ownership of SDA between master and slave can be checked exactly. With all eight register codes reachable, the bench covers pair alternation in both directions, the polarity path and the pointer hand-over on a repeated START.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 3;
    localparam int STRAP_W = 3;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } slave_state_e;

    // register pair groups selected by pointer bits [2:1]
    localparam logic [1:0] GRP_INPUT  = 2'd0;
    localparam logic [1:0] GRP_OUTPUT = 2'd1;
    localparam logic [1:0] GRP_POLAR  = 2'd2;
    localparam logic [1:0] GRP_CONFIG = 2'd3;
endpackage

// File: rtl/i2cx_line_sync.sv
module i2cx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else begin
                    scl_pipe[g] <= scl_pin;
                    sda_pipe[g] <= sda_pin;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else begin
                    scl_pipe[g] <= scl_pipe[g-1];
                    sda_pipe[g] <= sda_pipe[g-1];
                end
            end
        end
    end

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    assign sda_lvl   = sda_now;
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/i2cx_regfile.sv
module i2cx_regfile
    import i2cx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  ptr_t              wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  ptr_t              rd_idx,
    input  logic [BYTE_W-1:0] port0,
    input  logic [BYTE_W-1:0] port1,
    output logic [BYTE_W-1:0] rd_data
);
    logic [1:0][BYTE_W-1:0] out_q;
    logic [1:0][BYTE_W-1:0] pol_q;
    logic [1:0][BYTE_W-1:0] cfg_q;
    logic [1:0][BYTE_W-1:0] pins;

    assign pins = {port1, port0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '1;
            pol_q <= '0;
            cfg_q <= '1;
        end else if (wr_en) begin
            unique case (wr_idx[2:1])
                GRP_INPUT:  ;
                GRP_OUTPUT: out_q[wr_idx[0]] <= wr_data;
                GRP_POLAR:  pol_q[wr_idx[0]] <= wr_data;
                GRP_CONFIG: cfg_q[wr_idx[0]] <= wr_data;
            endcase
        end
    end

    always_comb begin
        unique case (rd_idx[2:1])
            GRP_INPUT:  rd_data = pins[rd_idx[0]] ^ pol_q[rd_idx[0]];
            GRP_OUTPUT: rd_data = out_q[rd_idx[0]];
            GRP_POLAR:  rd_data = pol_q[rd_idx[0]];
            GRP_CONFIG: rd_data = cfg_q[rd_idx[0]];
        endcase
    end

    // R10: a write aimed at an input code leaves every stored register unchanged
    p_input_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx[2:1] == GRP_INPUT) |=>
            ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));
endmodule

// File: rtl/i2cx_ctrl.sv
module i2cx_ctrl
    import i2cx_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_data,
    output ptr_t               rd_idx,
    output logic               wr_en,
    output ptr_t               wr_idx,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               sda_oe
);
    localparam logic [3:0] BITS_IN  = 4'd8;
    localparam logic [3:0] LAST_OUT = 4'd7;

    slave_state_e state_q, state_d;

    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] tx_buf;
    logic              rw_q;
    logic              mack_q;
    logic              rd_active;
    ptr_t              cmd_ptr;
    ptr_t              cur_ptr;
    logic              addr_ok;
    logic              rx_done;

    assign addr_ok = (rx_sh[7:1] == {ADDR_HI, strap});
    assign rx_done = scl_fall && (bitcnt == BITS_IN);
    assign rd_idx  = (state_q == ST_RD_ACK) ? (cur_ptr ^ ptr_t'(1)) : cur_ptr;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = ST_IDLE;
            ST_ADDR:     if (rx_done) state_d = addr_ok ? ST_ADDR_ACK : ST_IDLE;
            ST_ADDR_ACK: if (scl_fall) state_d = rw_q ? ST_RD : ST_CMD;
            ST_CMD:      if (rx_done) state_d = ST_CMD_ACK;
            ST_CMD_ACK:  if (scl_fall) state_d = ST_WR;
            ST_WR:       if (rx_done) state_d = ST_WR_ACK;
            ST_WR_ACK:   if (scl_fall) state_d = ST_WR;
            ST_RD:       if (scl_fall && bitcnt == LAST_OUT) state_d = ST_RD_ACK;
            ST_RD_ACK:   if (scl_fall) state_d = mack_q ? ST_RD : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (stop_det)  state_d = ST_IDLE;
        if (start_det) state_d = ST_ADDR;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            tx_buf    <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            rd_active <= 1'b0;
            cmd_ptr   <= '0;
            cur_ptr   <= '0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                bitcnt    <= '0;
                sda_oe    <= 1'b0;
                rd_active <= 1'b0;
                if (rd_active) cmd_ptr <= cur_ptr;
            end else if (stop_det) begin
                bitcnt    <= '0;
                sda_oe    <= 1'b0;
                rd_active <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_ADDR, ST_CMD, ST_WR: begin
                        if (scl_rise && bitcnt < BITS_IN) begin
                            rx_sh  <= {rx_sh[BYTE_W-2:0], sda_lvl};
                            bitcnt <= bitcnt + 4'd1;
                        end
                        if (rx_done) begin
                            bitcnt <= '0;
                            if (state_q == ST_ADDR) begin
                                if (addr_ok) begin
                                    sda_oe <= 1'b1;
                                    rw_q   <= rx_sh[0];
                                    if (rx_sh[0]) cur_ptr <= cmd_ptr;
                                end
                            end else if (state_q == ST_CMD) begin
                                sda_oe  <= 1'b1;
                                cmd_ptr <= rx_sh[PTR_W-1:0];
                                cur_ptr <= rx_sh[PTR_W-1:0];
                            end else begin
                                sda_oe  <= 1'b1;
                                wr_en   <= 1'b1;
                                wr_idx  <= cur_ptr;
                                wr_data <= rx_sh;
                                cur_ptr <= cur_ptr ^ ptr_t'(1);
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_rise && rw_q) tx_buf <= rd_data;
                        if (scl_fall) begin
                            if (rw_q) begin
                                tx_sh     <= tx_buf;
                                sda_oe    <= ~tx_buf[BYTE_W-1];
                                bitcnt    <= '0;
                                rd_active <= 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_CMD_ACK, ST_WR_ACK: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bitcnt == LAST_OUT) begin
                                sda_oe <= 1'b0;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_lvl;
                            if (!sda_lvl) begin
                                cur_ptr <= cur_ptr ^ ptr_t'(1);
                                tx_buf  <= rd_data;
                            end
                        end
                        if (scl_fall && mack_q) begin
                            tx_sh  <= tx_buf;
                            sda_oe <= ~tx_buf[BYTE_W-1];
                            bitcnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: an idle slave never pulls the data line
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe);

    // R1: while in the address acknowledge slot the line is pulled low
    p_addr_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK) |-> sda_oe);

    // R9: STOP always lands in idle
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE));

    // R6: repeated START in a read hands the live register code to the stored pointer
    p_restart_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && rd_active) |=> (cmd_ptr == $past(cur_ptr)));

    // R4: a master ACK moves the read to the partner register
    p_pair_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACK && scl_rise && !sda_lvl && !start_det && !stop_det)
            |=> (cur_ptr == ($past(cur_ptr) ^ ptr_t'(1))));
endmodule

// File: rtl/i2c_pair_slave.sv
module i2c_pair_slave
    import i2cx_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b0100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  port0_i,
    input  logic [BYTE_W-1:0]  port1_i
);
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    ptr_t              rd_idx;
    ptr_t              wr_idx;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;

    i2cx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_pin   (scl_i),
        .sda_pin   (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cx_ctrl #(.ADDR_HI(ADDR_HI)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap_i),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    i2cx_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .port0   (port0_i),
        .port1   (port1_i),
        .rd_data (rd_data)
    );
endmodule

// File: tb/i2c_pair_slave_tb.sv
module i2c_pair_slave_tb;
    localparam int Q = 10;
    localparam logic [7:0] A_WR  = 8'h4A;
    localparam logic [7:0] A_RD  = 8'h4B;
    localparam logic [7:0] A_BAD = 8'h4E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [7:0] in0 = 8'h3C;
    logic [7:0] in1 = 8'hA5;
    logic m_own = 1'b0;
    logic done = 1'b0;

    int total = 0;
    int bad = 0;
    int viol = 0;

    logic [7:0] mreg [8];
    int mptr = 0;
    int mcur = 0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_pair_slave u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .strap_i (3'b101),
        .port0_i (in0),
        .port1_i (in1)
    );

    // per-clock reference of bus ownership (R8)
    always @(negedge clk) begin
        if (rst_n && m_own && sda_oe) viol++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] expv(input int i);
        if (i == 0) return in0 ^ mreg[4];
        if (i == 1) return in1 ^ mreg[5];
        return mreg[i];
    endfunction

    task automatic bus_start();
        m_own = 1'b1; sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; m_own = 1'b0; tick(Q);
    endtask

    task automatic bus_restart();
        m_own = 1'b1; sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; m_own = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_own = 1'b1; sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
        m_own = 1'b0;
    endtask

    task automatic put_bit(input logic b);
        m_own = 1'b1; sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        m_own = 1'b0; scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!mack);
    endtask

    task automatic reg_write(input logic [7:0] cmd, input logic [7:0] d0, input logic [7:0] d1,
                             input int n, input string req);
        bit ak;
        bus_start();
        put_byte(A_WR, ak); chk(ak, req, ak, 1);
        put_byte(cmd, ak);  chk(ak, req, ak, 1);
        mptr = int'(cmd[2:0]); mcur = mptr;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = (i == 0) ? d0 : d1;
            put_byte(d, ak);
            if (mcur >= 2) mreg[mcur] = d;
            mcur ^= 1;
        end
        bus_stop();
    endtask

    task automatic read_seq(input int n, input string req);
        logic [7:0] v;
        logic [7:0] e;
        bit ak;
        put_byte(A_RD, ak); chk(ak, req, ak, 1);
        mcur = mptr;
        for (int i = 0; i < n; i++) begin
            e = expv(mcur);
            get_byte(i < n - 1, v);
            chk(v === e, req, v, e);
            if (i < n - 1) mcur ^= 1;
        end
    endtask

    task automatic reg_read(input logic [7:0] cmd, input int n, input string req);
        bit ak;
        bus_start();
        put_byte(A_WR, ak);
        put_byte(cmd, ak);
        mptr = int'(cmd[2:0]);
        bus_restart();
        read_seq(n, req);
        bus_stop();
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] e;
        bit ak;
        mreg[0] = 8'h00; mreg[1] = 8'h00;
        mreg[2] = 8'hFF; mreg[3] = 8'hFF;
        mreg[4] = 8'h00; mreg[5] = 8'h00;
        mreg[6] = 8'hFF; mreg[7] = 8'hFF;
        tick(5);
        chk(sda_oe === 1'b0, "R11 sda released in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(5);

        // R11: reset contents, plain read from pointer 0 with no command
        bus_start();
        read_seq(2, "R11 reset pointer/input");
        bus_stop();
        reg_read(8'h06, 2, "R11 config reset");
        reg_read(8'h04, 2, "R11 polarity reset");

        // R1: mismatched strap bit is not acknowledged
        bus_start();
        put_byte(A_BAD, ak);
        chk(!ak, "R1 wrong address nacked", ak, 0);
        put_byte(8'h00, ak);
        chk(!ak, "R1 silent until START", ak, 0);
        bus_stop();

        // R3/R4: write output pair, read it with long alternation
        reg_write(8'h02, 8'h12, 8'h34, 2, "R3 write output pair");
        reg_read(8'h02, 5, "R4 alternate 2/3");
        reg_read(8'h03, 3, "R4 start on odd code");

        // R2: upper command bits ignored
        reg_write(8'hF3, 8'h5A, 8'h00, 1, "R2 masked command");
        reg_read(8'h03, 1, "R2 masked command readback");

        // R5: polarity masks applied to inputs
        reg_write(8'h04, 8'hFF, 8'h0F, 2, "R5 polarity write");
        reg_read(8'h00, 4, "R5 inverted inputs");

        // R10: writes to input codes ignored
        reg_write(8'h00, 8'h99, 8'h77, 2, "R10 input write");
        reg_read(8'h04, 2, "R10 neighbours intact");
        reg_read(8'h02, 2, "R10 outputs intact");

        // R6: repeated START mid-read moves the pointer to the last register read
        bus_start();
        put_byte(A_WR, ak);
        put_byte(8'h01, ak);
        mptr = 1;
        bus_restart();
        read_seq(2, "R6 first read");
        mptr = mcur;
        bus_restart();
        read_seq(1, "R6 resumes at last register");
        chk(mptr == 0, "R6 pointer is input 0", mptr, 0);
        bus_stop();
        bus_start();
        read_seq(1, "R6 pointer persists");
        bus_stop();

        // R7: byte fixed at the acknowledge rising edge
        reg_write(8'h00, 8'h00, 8'h00, 0, "R7 set pointer");
        bus_start();
        put_byte(A_RD, ak);
        e = expv(0);
        in0 = 8'hC3;
        get_byte(1'b1, v);
        chk(v === e, "R7 input change after capture", v, e);
        e = expv(1);
        get_byte(1'b1, v);
        chk(v === e, "R7 partner captured at ack", v, e);
        e = expv(0);
        get_byte(1'b0, v);
        chk(v === e, "R7 new input seen next time", v, e);
        bus_stop();

        // R9: STOP in the middle of a command byte
        mptr = 0;
        bus_start();
        put_byte(A_WR, ak);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        bus_start();
        read_seq(1, "R9 pointer not disturbed by aborted byte");
        bus_stop();
        reg_read(8'h07, 2, "R9 normal transfer after abort");

        // R8: ownership never violated
        chk(viol == 0, "R8 slave drove SDA in master phase", viol, 0);
        chk(sda_oe === 1'b0, "R8 released after NACK", sda_oe, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule